// File: doc/BRIEF.md
# Hash Engine Register Front-End

This block sits between a 32-bit register bus and a multi-algorithm hash core. Software programs a 64-bit message length in bits and then writes a control word that selects the digest algorithm and the byte order of incoming data. That control write starts a new message. Data then arrives one 32-bit word per write on a separate data port. Each word is reordered, trimmed to the programmed length and handed to the core with a byte-valid mask and an end-of-message flag.

When the core finishes, it returns the whole digest. The block loads the digest into a queue that software drains one word per read. Four status conditions are tracked: results waiting, a new result set, a read from an empty queue, and a data write that could not be taken. Each condition is gated by an enable to form one registered interrupt line.

A synchronous active-high `rst` and a software reset bit both return the block to its idle state. The hash rounds themselves live outside this block.

Top module: `hashfe_top`

## Requirements
- R1: After `rst`, the status register (0x10) reads 0, the enable register (0x14) reads 0, `irq` is 0, and the revision register (0x50) reads the REVISION parameter (default 0x00010002).
- R2: Writing 1 to bit 0 at 0x00 holds the block in soft reset until 0 is written there. While it is held, the digest queue, the status bits and the enables are cleared, and writes to the other registers are ignored.
- R3: A write to the control register at 0x0C takes the algorithm from bits [1:0] (0 MD5, 1 SHA-1, 2 SHA-224, 3 SHA-256) and the byte order from bits [9:8]. In the cycle after that write, `core_start` is high for one cycle, `core_algo` shows the algorithm, and `core_bitlen` equals {word at 0x04, word at 0x08}.
- R4: A data write in the same cycle as the control write, or in the cycle right after it, is dropped and sets status bit 3. A data write two cycles after the control write is accepted.
- R5: Take input byte lanes b3=[31:24], b2, b1, b0=[7:0]. An accepted word reaches `core_word` one cycle later in one of four orders: byte order 0 gives {b3,b2,b1,b0}, 1 gives {b0,b1,b2,b3}, 2 gives {b2,b3,b1,b0}, and 3 gives {b1,b0,b3,b2}.
- R6: For each accepted word, let r be the bits of the message still unsent. `core_keep` is 4'b1111 when r >= 32. Otherwise its top ceil(r/8) bits are set, with bit 3 marking lane [31:24]. Bytes outside the mask read as zero. `core_word_last` is set on the word that brings r to 0.
- R7: A data write that arrives when no message is configured, or after all programmed bits have been sent, produces no `core_word_vld` and sets status bit 3.
- R8: When `core_done` is high, the digest queue is loaded with 4, 5, 7 or 8 words for algorithm 0, 1, 2 or 3, and status bit 1 is set. Each read of 0x1C pops one word, starting with `core_digest[255:224]`. Status bit 0 reads 1 while the queue holds words.
- R9: A read of 0x1C with the queue empty returns 0 and sets status bit 2.
- R10: Writing ones to 0x18 clears the matching status bits among 1, 2 and 3. Bit 0 follows the queue occupancy and is not cleared by that write.
- R11: Status bit 8 is the OR of status bits [3:0] ANDed with enable bits [3:0]. `irq` takes that value one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Register byte address |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data, valid the cycle after `bus_rd` |
| dat_wr | input | 1 | Data port write strobe |
| dat_wdata | input | 32 | Data port word |
| core_start | output | 1 | One-cycle start pulse to the core |
| core_algo | output | 2 | Algorithm select |
| core_bitlen | output | 64 | Message length in bits |
| core_word_vld | output | 1 | Data word valid toward the core |
| core_word | output | 32 | Reordered, trimmed data word |
| core_keep | output | 4 | Byte-valid mask, bit 3 for [31:24] |
| core_word_last | output | 1 | Last word of the message |
| core_done | input | 1 | Digest ready from the core |
| core_digest | input | DQ_DEPTH*32 | Digest, first word in the top bits |
| irq | output | 1 | Registered interrupt |

## Verification
The bench builds the block with its default parameters: 32-bit words, a 64-bit length, an eight-word digest queue and a two-cycle gap after the control write. This small setting allows a sweep over every bit length from 0 to 96. That range covers every mask shape, message lengths of zero to three words, all four byte orders and all four algorithms, with each digest drained past its end. Separate runs cover the control-to-data gap, including a data write in the same cycle as the control write, as well as interrupt latency and masking, the clear register against live occupancy, soft reset, and the upper length word.

// File: rtl/hashfe_pkg.sv
package hashfe_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned LANES  = WORD_W / 8;

  // status bit positions
  localparam int unsigned ST_AVAIL  = 0;
  localparam int unsigned ST_NEWSET = 1;
  localparam int unsigned ST_RDERR  = 2;
  localparam int unsigned ST_WRERR  = 3;
  localparam int unsigned ST_ANY    = 8;

  typedef enum logic [1:0] {
    ALG_MD5    = 2'd0,
    ALG_SHA1   = 2'd1,
    ALG_SHA224 = 2'd2,
    ALG_SHA256 = 2'd3
  } hash_alg_e;

  typedef enum logic [1:0] {
    ORD_PASS = 2'd0,
    ORD_FULL = 2'd1,
    ORD_HIGH = 2'd2,
    ORD_PAIR = 2'd3
  } lane_ord_e;

  function automatic int unsigned digest_len(input logic [1:0] alg);
    case (hash_alg_e'(alg))
      ALG_MD5:    return 4;
      ALG_SHA1:   return 5;
      ALG_SHA224: return 7;
      default:    return 8;
    endcase
  endfunction
endpackage

// File: rtl/hashfe_lane_swap.sv
module hashfe_lane_swap
  import hashfe_pkg::*;
(
  input  logic [1:0]        order_i,
  input  logic [WORD_W-1:0] word_i,
  output logic [WORD_W-1:0] word_o
);
  logic [LANES-1:0][7:0] b;
  assign b = word_i;

  always_comb begin
    case (lane_ord_e'(order_i))
      ORD_PASS: word_o = word_i;
      ORD_FULL: word_o = {b[0], b[1], b[2], b[3]};
      ORD_HIGH: word_o = {b[2], b[3], b[1], b[0]};
      default:  word_o = {b[1], b[0], b[3], b[2]};
    endcase
  end
endmodule

// File: rtl/hashfe_feed.sv
module hashfe_feed
  import hashfe_pkg::*;
#(
  parameter int unsigned LEN_W   = 64,
  parameter int unsigned MIN_GAP = 2
) (
  input  logic              clk,
  input  logic              clr,
  input  logic              arm_i,
  input  logic [LEN_W-1:0]  arm_bits_i,
  input  logic [1:0]        arm_order_i,
  input  logic              dat_wr_i,
  input  logic [WORD_W-1:0] dat_i,
  output logic              out_vld_o,
  output logic [WORD_W-1:0] out_word_o,
  output logic [LANES-1:0]  out_keep_o,
  output logic              out_last_o,
  output logic              err_o
);
  localparam int unsigned GAP_W = $clog2(MIN_GAP + 1);
  localparam logic [GAP_W-1:0] GAP_LOAD = GAP_W'(MIN_GAP - 1);
  localparam logic [LEN_W-1:0] WORD_BITS = LEN_W'(WORD_W);
  localparam int unsigned LOW_W = $clog2(WORD_W) + 1;
  localparam int unsigned NB_W  = $clog2(LANES + 1);

  logic              armed_q;
  logic [GAP_W-1:0]  gap_q;
  logic [LEN_W-1:0]  rem_q;
  logic [1:0]        order_q;
  logic [WORD_W-1:0] swapped;
  logic [WORD_W-1:0] trimmed;
  logic [LANES-1:0]  mask;
  logic              rem_full;
  logic [LOW_W-1:0]  rnd;
  logic [NB_W-1:0]   nbytes;
  logic              accept;

  hashfe_lane_swap u_swap (
    .order_i (order_q),
    .word_i  (dat_i),
    .word_o  (swapped)
  );

  assign rem_full = (rem_q >= WORD_BITS);
  assign rnd      = rem_q[LOW_W-1:0] + LOW_W'(7);
  assign nbytes   = rem_full ? NB_W'(LANES) : NB_W'(rnd >> 3);

  // message order is the top lane first
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign mask[i] = (NB_W'(LANES - 1 - i) < nbytes);
    assign trimmed[8*i +: 8] = mask[i] ? swapped[8*i +: 8] : 8'h00;
  end

  assign accept = dat_wr_i && armed_q && (gap_q == '0) && (rem_q != '0) && !arm_i;
  assign err_o  = dat_wr_i && !accept;

  always_ff @(posedge clk) begin
    if (clr) begin
      armed_q    <= 1'b0;
      gap_q      <= '0;
      rem_q      <= '0;
      order_q    <= '0;
      out_vld_o  <= 1'b0;
      out_word_o <= '0;
      out_keep_o <= '0;
      out_last_o <= 1'b0;
    end else begin
      out_vld_o <= accept;
      if (arm_i) begin
        armed_q <= 1'b1;
        gap_q   <= GAP_LOAD;
        rem_q   <= arm_bits_i;
        order_q <= arm_order_i;
      end else begin
        if (gap_q != '0) gap_q <= gap_q - 1'b1;
        if (accept) rem_q <= (rem_q > WORD_BITS) ? rem_q - WORD_BITS : '0;
      end
      if (accept) begin
        out_word_o <= trimmed;
        out_keep_o <= mask;
        out_last_o <= (rem_q <= WORD_BITS);
      end
    end
  end
endmodule

// File: rtl/hashfe_digest_queue.sv
module hashfe_digest_queue #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned W     = 32
) (
  input  logic                         clk,
  input  logic                         clr,
  input  logic                         load_i,
  input  logic [$clog2(DEPTH+1)-1:0]   load_cnt_i,
  input  logic [DEPTH*W-1:0]           load_data_i,
  input  logic                         pop_i,
  output logic [W-1:0]                 head_o,
  output logic                         empty_o,
  output logic                         underflow_o
);
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);
  localparam int unsigned PTR_W = $clog2(DEPTH);

  logic [DEPTH-1:0][W-1:0] mem_q;
  logic [CNT_W-1:0]        cnt_q;
  logic [PTR_W-1:0]        ptr_q;

  assign empty_o     = (cnt_q == '0);
  assign head_o      = mem_q[ptr_q];
  assign underflow_o = pop_i && empty_o;

  always_ff @(posedge clk) begin
    if (load_i) begin
      for (int i = 0; i < DEPTH; i++)
        mem_q[i] <= load_data_i[(DEPTH-1-i)*W +: W];
    end
  end

  always_ff @(posedge clk) begin
    if (clr) begin
      cnt_q <= '0;
      ptr_q <= '0;
    end else if (load_i) begin
      cnt_q <= load_cnt_i;
      ptr_q <= '0;
    end else if (pop_i && !empty_o) begin
      cnt_q <= cnt_q - 1'b1;
      ptr_q <= ptr_q + 1'b1;
    end
  end
endmodule

// File: rtl/hashfe_top.sv
module hashfe_top
  import hashfe_pkg::*;
#(
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned MIN_GAP  = 2,
  parameter int unsigned DQ_DEPTH = 8,
  parameter logic [31:0] REVISION = 32'h0001_0002
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     bus_wr,
  input  logic                     bus_rd,
  input  logic [ADDR_W-1:0]        bus_addr,
  input  logic [31:0]              bus_wdata,
  output logic [31:0]              bus_rdata,
  input  logic                     dat_wr,
  input  logic [31:0]              dat_wdata,
  output logic                     core_start,
  output logic [1:0]               core_algo,
  output logic [63:0]              core_bitlen,
  output logic                     core_word_vld,
  output logic [31:0]              core_word,
  output logic [3:0]               core_keep,
  output logic                     core_word_last,
  input  logic                     core_done,
  input  logic [DQ_DEPTH*32-1:0]   core_digest,
  output logic                     irq
);
  localparam int unsigned LEN_W    = 2 * WORD_W;
  localparam int unsigned DQ_CNT_W = $clog2(DQ_DEPTH + 1);

  localparam logic [ADDR_W-1:0] A_SRST = ADDR_W'(8'h00);
  localparam logic [ADDR_W-1:0] A_LENH = ADDR_W'(8'h04);
  localparam logic [ADDR_W-1:0] A_LENL = ADDR_W'(8'h08);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(8'h0C);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(8'h10);
  localparam logic [ADDR_W-1:0] A_IEN  = ADDR_W'(8'h14);
  localparam logic [ADDR_W-1:0] A_ICLR = ADDR_W'(8'h18);
  localparam logic [ADDR_W-1:0] A_RQ   = ADDR_W'(8'h1C);
  localparam logic [ADDR_W-1:0] A_REV  = ADDR_W'(8'h50);

  logic        srst_q;
  logic        clr;
  logic        wr_ok;
  logic        ctrl_wr;
  logic        pop;
  logic [31:0] len_hi_q;
  logic [31:0] len_lo_q;
  logic [1:0]  ord_q;
  logic [3:0]  irq_en;
  logic        new_q;
  logic        rderr_q;
  logic        wrerr_q;
  logic        irq_q;
  logic        feed_err;
  logic        q_empty;
  logic        q_under;
  logic [31:0] q_head;
  logic [3:0]  stat4;
  logic        any_pend;
  logic [31:0] status_word;
  logic        clr_hit;

  assign clr     = rst | srst_q;
  assign wr_ok   = bus_wr && !srst_q;
  assign ctrl_wr = wr_ok && (bus_addr == A_CTRL);
  assign pop     = bus_rd && !srst_q && (bus_addr == A_RQ);
  assign clr_hit = wr_ok && (bus_addr == A_ICLR);

  hashfe_feed #(
    .LEN_W   (LEN_W),
    .MIN_GAP (MIN_GAP)
  ) u_feed (
    .clk         (clk),
    .clr         (clr),
    .arm_i       (ctrl_wr),
    .arm_bits_i  ({len_hi_q, len_lo_q}),
    .arm_order_i (bus_wdata[9:8]),
    .dat_wr_i    (dat_wr),
    .dat_i       (dat_wdata),
    .out_vld_o   (core_word_vld),
    .out_word_o  (core_word),
    .out_keep_o  (core_keep),
    .out_last_o  (core_word_last),
    .err_o       (feed_err)
  );

  hashfe_digest_queue #(
    .DEPTH (DQ_DEPTH),
    .W     (WORD_W)
  ) u_queue (
    .clk         (clk),
    .clr         (clr),
    .load_i      (core_done),
    .load_cnt_i  (DQ_CNT_W'(digest_len(core_algo))),
    .load_data_i (core_digest),
    .pop_i       (pop),
    .head_o      (q_head),
    .empty_o     (q_empty),
    .underflow_o (q_under)
  );

  always_comb begin
    stat4            = '0;
    stat4[ST_AVAIL]  = !q_empty;
    stat4[ST_NEWSET] = new_q;
    stat4[ST_RDERR]  = rderr_q;
    stat4[ST_WRERR]  = wrerr_q;
    any_pend         = |(stat4 & irq_en);
    status_word         = '0;
    status_word[3:0]    = stat4;
    status_word[ST_ANY] = any_pend;
  end

  assign irq = irq_q;

  always_ff @(posedge clk) begin
    if (rst) srst_q <= 1'b0;
    else if (bus_wr && (bus_addr == A_SRST)) srst_q <= bus_wdata[0];
  end

  always_ff @(posedge clk) begin
    if (clr) begin
      len_hi_q    <= '0;
      len_lo_q    <= '0;
      ord_q       <= '0;
      irq_en      <= '0;
      new_q       <= 1'b0;
      rderr_q     <= 1'b0;
      wrerr_q     <= 1'b0;
      irq_q       <= 1'b0;
      core_start  <= 1'b0;
      core_algo   <= '0;
      core_bitlen <= '0;
    end else begin
      if (wr_ok && (bus_addr == A_LENH)) len_hi_q <= bus_wdata;
      if (wr_ok && (bus_addr == A_LENL)) len_lo_q <= bus_wdata;
      if (wr_ok && (bus_addr == A_IEN))  irq_en   <= bus_wdata[3:0];
      core_start <= ctrl_wr;
      if (ctrl_wr) begin
        ord_q       <= bus_wdata[9:8];
        core_algo   <= bus_wdata[1:0];
        core_bitlen <= {len_hi_q, len_lo_q};
      end
      // a new event in the same cycle as a clear keeps its bit
      new_q   <= (new_q   && !(clr_hit && bus_wdata[ST_NEWSET])) || core_done;
      rderr_q <= (rderr_q && !(clr_hit && bus_wdata[ST_RDERR]))  || q_under;
      wrerr_q <= (wrerr_q && !(clr_hit && bus_wdata[ST_WRERR]))  || feed_err;
      irq_q   <= any_pend;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      case (bus_addr)
        A_SRST:  bus_rdata <= {31'b0, srst_q};
        A_LENH:  bus_rdata <= len_hi_q;
        A_LENL:  bus_rdata <= len_lo_q;
        A_CTRL:  bus_rdata <= {22'b0, ord_q, 6'b0, core_algo};
        A_STAT:  bus_rdata <= status_word;
        A_IEN:   bus_rdata <= {28'b0, irq_en};
        A_RQ:    bus_rdata <= q_empty ? 32'h0 : q_head;
        A_REV:   bus_rdata <= REVISION;
        default: bus_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/hashfe_checker.sv
module hashfe_checker (
  input logic        clk,
  input logic        rst,
  input logic        ctrl_wr,
  input logic        dat_wr,
  input logic        srst_q,
  input logic        q_empty,
  input logic        pop,
  input logic [3:0]  irq_en,
  input logic        core_word_vld,
  input logic [3:0]  core_keep,
  input logic        core_word_last,
  input logic [31:0] bus_rdata,
  input logic        irq
);
  AST_GAP_SAME_CYCLE: assert property (@(posedge clk) disable iff (rst)
    (ctrl_wr && dat_wr) |=> !core_word_vld); // R4
  AST_GAP_NEXT_CYCLE: assert property (@(posedge clk) disable iff (rst)
    ($past(ctrl_wr) && dat_wr && !ctrl_wr) |=> !core_word_vld); // R4
  AST_KEEP_SHAPE: assert property (@(posedge clk) disable iff (rst)
    core_word_vld |-> (core_keep == 4'b1000 || core_keep == 4'b1100 ||
                       core_keep == 4'b1110 || core_keep == 4'b1111)); // R6
  AST_FULL_BEFORE_LAST: assert property (@(posedge clk) disable iff (rst)
    (core_word_vld && !core_word_last) |-> (core_keep == 4'b1111)); // R6
  AST_EMPTY_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
    (pop && q_empty) |=> (bus_rdata == 32'h0)); // R9
  AST_SRST_QUIET: assert property (@(posedge clk) disable iff (rst)
    srst_q |=> (!irq && !core_word_vld)); // R2
  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (rst)
    ($past(irq_en) == 4'h0) |-> !irq); // R11
endmodule

bind hashfe_top hashfe_checker chk_i (
  .clk            (clk),
  .rst            (rst),
  .ctrl_wr        (ctrl_wr),
  .dat_wr         (dat_wr),
  .srst_q         (srst_q),
  .q_empty        (q_empty),
  .pop            (pop),
  .irq_en         (irq_en),
  .core_word_vld  (core_word_vld),
  .core_keep      (core_keep),
  .core_word_last (core_word_last),
  .bus_rdata      (bus_rdata),
  .irq            (irq)
);

// File: tb/hashfe_top_tb_top.sv
module hashfe_top_tb_top;
  logic         clk = 1'b0;
  logic         rst;
  logic         bus_wr, bus_rd;
  logic [7:0]   bus_addr;
  logic [31:0]  bus_wdata, bus_rdata;
  logic         dat_wr;
  logic [31:0]  dat_wdata;
  logic         core_start;
  logic [1:0]   core_algo;
  logic [63:0]  core_bitlen;
  logic         core_word_vld;
  logic [31:0]  core_word;
  logic [3:0]   core_keep;
  logic         core_word_last;
  logic         core_done;
  logic [255:0] core_digest;
  logic         irq;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;
  int exp_msg = 0;
  logic [15:0] stub_msg;

  always #2 clk = ~clk;

  hashfe_top dut_i (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .dat_wr(dat_wr), .dat_wdata(dat_wdata),
    .core_start(core_start), .core_algo(core_algo), .core_bitlen(core_bitlen),
    .core_word_vld(core_word_vld), .core_word(core_word), .core_keep(core_keep),
    .core_word_last(core_word_last), .core_done(core_done), .core_digest(core_digest),
    .irq(irq)
  );

  // core stub: digest one cycle after the last word
  function automatic logic [31:0] dig_word(input int k, input logic [15:0] m);
    return {8'(8'hA0 + k), 8'h5A, m};
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      core_done <= 1'b0;
      stub_msg  <= '0;
    end else begin
      core_done <= core_word_vld && core_word_last;
      if (core_word_vld && core_word_last) stub_msg <= stub_msg + 1'b1;
    end
  end

  for (genvar k = 0; k < 8; k++) begin : g_dig
    assign core_digest[255-32*k -: 32] = dig_word(k, stub_msg);
  end

  function automatic logic [31:0] exp_order(input logic [31:0] w, input int o);
    logic [7:0] b3, b2, b1, b0;
    {b3, b2, b1, b0} = w;
    case (o)
      0: return {b3, b2, b1, b0};
      1: return {b0, b1, b2, b3};
      2: return {b2, b3, b1, b0};
      default: return {b1, b0, b3, b2};
    endcase
  endfunction

  function automatic logic [3:0] exp_keep(input int rem);
    if (rem >= 32) return 4'hF;
    return ~(4'hF >> ((rem + 7) / 8));
  endfunction

  function automatic logic [31:0] exp_trim(input logic [31:0] w, input logic [3:0] m);
    logic [31:0] r;
    for (int i = 0; i < 4; i++) r[8*i +: 8] = m[i] ? w[8*i +: 8] : 8'h00;
    return r;
  endfunction

  function automatic int dlen(input int a);
    case (a)
      0: return 4;
      1: return 5;
      2: return 7;
      default: return 8;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic dwr(input logic [31:0] w);
    dat_wr = 1'b1; dat_wdata = w;
    @(negedge clk);
    dat_wr = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog actual=running expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    logic [31:0] w;
    int rem, nw, algo, ord;
    rst = 1'b1; bus_wr = 0; bus_rd = 0; bus_addr = 0; bus_wdata = 0;
    dat_wr = 0; dat_wdata = 0;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    chk("R1 irq", 64'(irq), 64'd0);
    rd(8'h10, r); chk("R1 status", 64'(r), 64'h0);
    rd(8'h14, r); chk("R1 enable", 64'(r), 64'h0);
    rd(8'h50, r); chk("R1 revision", 64'(r), 64'h0001_0002);

    // sweep of bit lengths: R3 R5 R6 R7 R8 R9 R10
    for (int L = 0; L <= 96; L++) begin
      algo = L % 4;
      ord  = (L / 4) % 4;
      wr(8'h04, 32'h0);
      wr(8'h08, 32'(L));
      wr(8'h0C, 32'((ord << 8) | algo));
      chk("R3 start", 64'(core_start), 64'd1);
      chk("R3 algo", 64'(core_algo), 64'(algo));
      chk("R3 bitlen", core_bitlen, 64'(L));
      @(negedge clk);
      nw = (L + 31) / 32;
      rem = L;
      for (int j = 0; j < nw; j++) begin
        w = (32'h0102_0304 * 32'(j + 1)) ^ 32'(L * 32'h0001_0101);
        dwr(w);
        chk("R5 R6 vld", 64'(core_word_vld), 64'd1);
        chk("R5 R6 word", 64'(core_word), 64'(exp_trim(exp_order(w, ord), exp_keep(rem))));
        chk("R6 keep", 64'(core_keep), 64'(exp_keep(rem)));
        chk("R6 last", 64'(core_word_last), 64'(j == nw - 1));
        rem = (rem > 32) ? rem - 32 : 0;
      end
      dwr(32'hDEAD_BEEF);
      chk("R7 extra dropped", 64'(core_word_vld), 64'd0);
      repeat (3) @(negedge clk);
      if (nw > 0) begin
        exp_msg++;
        rd(8'h10, r); chk("R8 status loaded", 64'(r), 64'hB);
        for (int k = 0; k < dlen(algo); k++) begin
          rd(8'h1C, r); chk("R8 digest word", 64'(r), 64'(dig_word(k, 16'(exp_msg))));
        end
        rd(8'h1C, r); chk("R9 empty read", 64'(r), 64'h0);
        rd(8'h10, r); chk("R9 status", 64'(r), 64'hE);
      end else begin
        rd(8'h10, r); chk("R7 status", 64'(r), 64'h8);
        rd(8'h1C, r); chk("R9 empty read", 64'(r), 64'h0);
        rd(8'h10, r); chk("R9 status", 64'(r), 64'hC);
      end
      wr(8'h18, 32'hF);
      rd(8'h10, r); chk("R10 cleared", 64'(r), 64'h0);
    end

    // R4 gap after control write
    wr(8'h04, 32'h0);
    wr(8'h08, 32'd64);
    bus_wr = 1'b1; bus_addr = 8'h0C; bus_wdata = 32'h0;
    dat_wr = 1'b1; dat_wdata = 32'h1111_1111;
    @(negedge clk);
    bus_wr = 1'b0; dat_wr = 1'b0;
    chk("R4 same cycle", 64'(core_word_vld), 64'd0);
    dwr(32'h2222_2222);
    chk("R4 next cycle", 64'(core_word_vld), 64'd0);
    dwr(32'h3333_3333);
    chk("R4 second cycle vld", 64'(core_word_vld), 64'd1);
    chk("R4 second cycle word", 64'(core_word), 64'h3333_3333);
    dwr(32'h4444_4444);
    chk("R4 last", 64'(core_word_last), 64'd1);
    exp_msg++;
    repeat (3) @(negedge clk);
    rd(8'h10, r); chk("R4 status", 64'(r), 64'hB);

    // R11 interrupt latency and masking
    wr(8'h14, 32'h2);
    chk("R11 irq lag", 64'(irq), 64'd0);
    @(negedge clk);
    chk("R11 irq set", 64'(irq), 64'd1);
    rd(8'h10, r); chk("R11 pending bit", 64'(r), 64'h10B);
    wr(8'h18, 32'hF);
    rd(8'h10, r); chk("R10 avail kept", 64'(r), 64'h1);
    chk("R11 irq drop", 64'(irq), 64'd0);
    wr(8'h14, 32'h1);
    @(negedge clk);
    chk("R11 avail irq", 64'(irq), 64'd1);
    wr(8'h14, 32'h0);
    @(negedge clk);
    chk("R11 masked", 64'(irq), 64'd0);

    // R2 soft reset
    wr(8'h00, 32'h1);
    wr(8'h14, 32'hF);
    rd(8'h10, r); chk("R2 status cleared", 64'(r), 64'h0);
    wr(8'h00, 32'h0);
    rd(8'h14, r); chk("R2 enable ignored", 64'(r), 64'h0);
    rd(8'h1C, r); chk("R2 queue cleared", 64'(r), 64'h0);
    rd(8'h10, r); chk("R2 R9 status", 64'(r), 64'h4);
    wr(8'h18, 32'hF);

    // R7 data with no message configured
    dwr(32'h5555_5555);
    chk("R7 unconfigured", 64'(core_word_vld), 64'd0);
    rd(8'h10, r); chk("R7 status", 64'(r), 64'h8);

    // R3 upper length word and control readback
    wr(8'h04, 32'h1);
    wr(8'h08, 32'h20);
    wr(8'h0C, 32'h0000_0203);
    chk("R3 high bitlen", core_bitlen, 64'h1_0000_0020);
    chk("R3 algo3", 64'(core_algo), 64'd3);
    rd(8'h0C, r); chk("R3 control read", 64'(r), 64'h203);
    wr(8'h00, 32'h1);
    wr(8'h00, 32'h0);

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule